// File: doc/BRIEF.md
# Crossing-Indexed Hit Store

This block keeps zero-suppressed detector hits sorted by the beam crossing that produced them, so that a trigger arriving later can collect every hit of one chosen crossing. Each hit comes with an 8-bit crossing number. The low six bits of that number pick one of 64 slots in a ring, and each slot holds up to eight 18-bit hit words. Next to the hit memory, every slot keeps three pieces of state: the full crossing number that currently owns it, a saturating hit count, and an overflow flag. When a hit from a newer crossing lands in a slot, that slot is taken over by resetting its count. Nothing is ever swept clean, so capture never stops.

A read request names one crossing. One cycle later the block pulses a done strobe and reports three things: whether the slot still belongs to that crossing, how many hits it holds, and whether any were lost. It then streams the stored words out one per cycle, in the order they were stored, and marks the final word. Hits keep being written while a stream is running, because the hit memory has one write port and one read port.

Top module: `xing_hit_store`

## Requirements
- R1: A hit with crossing number T is filed in slot T mod 64. Two crossings that differ by a multiple of 64 share a slot.
- R2: A slot stores up to 8 hit words, at in-slot positions 0..7, in the order the hits arrive.
- R3: A hit that arrives after its slot already holds 8 hits of the same crossing is discarded. The reported count stays 8 and the overflow flag reads 1.
- R4: The first hit whose crossing number differs from the slot's recorded owner takes over the slot. Afterwards the owner is the new number, the count is 1 and the overflow flag is 0.
- R5: A request for crossing T reports match=1 only when slot T mod 64 is owned by T. On a mismatch the reported count is 0 and the overflow flag is 0.
- R6: When a hit and a request address the same slot in the same cycle, the request reports the count as it stood before that hit.
- R7: After an accepted request with count N>0, out_vld is high for exactly N consecutive cycles, starting the cycle after rd_done. The words come out in storage order, and out_last is high only with the N-th word. When N=0 no word is sent.
- R8: rd_ready is low from acceptance until the last word has been sent. A request presented while rd_ready is low is ignored and produces no rd_done.
- R9: Each streamed word equals, bit for bit, the 18-bit hit_word that was presented with that hit.
- R10: After reset, rd_ready=1, out_vld=0 and rd_done=0. Every slot is owned by crossing 0 with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld | input | 1 | Hit strobe |
| hit_word | input | 18 | Hit payload to store |
| hit_tag | input | 8 | Crossing number of the hit |
| rd_req | input | 1 | Readout request |
| rd_tag | input | 8 | Crossing number requested |
| rd_ready | output | 1 | Readout port idle, request will be taken |
| rd_done | output | 1 | One-cycle strobe: lookup result valid |
| rd_match | output | 1 | Slot owned by the requested crossing |
| rd_count | output | 4 | Hits stored for the crossing (0..8) |
| rd_ovf | output | 1 | Hits were dropped for the crossing |
| out_vld | output | 1 | Streamed hit word valid |
| out_word | output | 18 | Streamed hit word |
| out_last | output | 1 | Final word of the stream |

## Verification
Two functions can act in the same cycle: a hit being filed and a readout being looked up or streamed. The bench provokes the lookup case on purpose. It presents a hit and a request for the same crossing on one edge, expects the count from before that hit, then reads again and expects the count to have gone up by one. During every stream it also injects hits into other slots and a stray request. It then checks that the streamed words, the model's later counts and the absence of a second done strobe all come out as predicted.

// File: rtl/xhs_pkg.sv
package xhs_pkg;
  localparam int XHS_SLOT_BITS = 6;
  localparam int XHS_HIT_BITS  = 3;
  localparam int XHS_TAG_W     = 8;
  localparam int XHS_WORD_W    = 18;
endpackage

// File: rtl/xhs_slot_table.sv
module xhs_slot_table #(
  parameter int SLOT_BITS = xhs_pkg::XHS_SLOT_BITS,
  parameter int HIT_BITS  = xhs_pkg::XHS_HIT_BITS,
  parameter int TAG_W     = xhs_pkg::XHS_TAG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [TAG_W-1:0]     wr_tag,
  output logic                 wr_store,
  output logic [SLOT_BITS-1:0] wr_slot,
  output logic [HIT_BITS-1:0]  wr_idx,
  input  logic [TAG_W-1:0]     lk_tag,
  output logic                 lk_match,
  output logic [HIT_BITS:0]    lk_count,
  output logic                 lk_ovf
);
  localparam int SLOTS = 1 << SLOT_BITS;
  localparam int HITS  = 1 << HIT_BITS;

  function automatic logic [SLOT_BITS-1:0] ring_slot(input logic [TAG_W-1:0] t);
    return t[SLOT_BITS-1:0];
  endfunction

  function automatic logic [HIT_BITS:0] sat_next(input logic [HIT_BITS:0] c);
    return (c == (HIT_BITS+1)'(HITS)) ? c : c + 1'b1;
  endfunction

  logic [TAG_W-1:0]    tag_q [SLOTS];
  logic [HIT_BITS:0]   cnt_q [SLOTS];
  logic [SLOTS-1:0]    ovf_q;
  logic                wr_reclaim, wr_drop;
  logic [HIT_BITS:0]   cur_cnt;
  logic [SLOT_BITS-1:0] lk_slot;

  always_comb begin
    wr_slot    = ring_slot(wr_tag);
    cur_cnt    = cnt_q[wr_slot];
    wr_reclaim = wr_en && (tag_q[wr_slot] != wr_tag);
    wr_drop    = wr_en && !wr_reclaim && (cur_cnt == (HIT_BITS+1)'(HITS));
    wr_store   = wr_en && !wr_drop;
    wr_idx     = wr_reclaim ? '0 : cur_cnt[HIT_BITS-1:0];
    lk_slot    = ring_slot(lk_tag);
    lk_match   = (tag_q[lk_slot] == lk_tag);
    lk_count   = lk_match ? cnt_q[lk_slot] : '0;
    lk_ovf     = lk_match && ovf_q[lk_slot];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
      end
      ovf_q <= '0;
    end else if (wr_en) begin
      if (wr_reclaim) begin
        tag_q[wr_slot] <= wr_tag;
        cnt_q[wr_slot] <= (HIT_BITS+1)'(1);
        ovf_q[wr_slot] <= 1'b0;
      end else if (wr_drop) begin
        ovf_q[wr_slot] <= 1'b1;
      end else begin
        cnt_q[wr_slot] <= sat_next(cur_cnt);
      end
    end
  end

  // R3: a dropped hit leaves the slot full and flagged
  assert_drop_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> ovf_q[$past(wr_slot)] && (cnt_q[$past(wr_slot)] == (HIT_BITS+1)'(HITS)));

  // R4: takeover restarts the slot for the new owner
  assert_reclaim_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reclaim |=> (cnt_q[$past(wr_slot)] == (HIT_BITS+1)'(1)) && !ovf_q[$past(wr_slot)]
                   && (tag_q[$past(wr_slot)] == $past(wr_tag)));
endmodule

// File: rtl/xhs_hit_mem.sv
module xhs_hit_mem #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/xhs_readout.sv
module xhs_readout #(
  parameter int SLOT_BITS = xhs_pkg::XHS_SLOT_BITS,
  parameter int HIT_BITS  = xhs_pkg::XHS_HIT_BITS,
  parameter int TAG_W     = xhs_pkg::XHS_TAG_W,
  parameter int WORD_W    = xhs_pkg::XHS_WORD_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_req,
  input  logic [TAG_W-1:0]              rd_tag,
  input  logic                          lk_match,
  input  logic [HIT_BITS:0]             lk_count,
  input  logic                          lk_ovf,
  output logic [SLOT_BITS+HIT_BITS-1:0] mem_raddr,
  input  logic [WORD_W-1:0]             mem_rdata,
  output logic                          rd_ready,
  output logic                          rd_done,
  output logic                          rd_match,
  output logic [HIT_BITS:0]             rd_count,
  output logic                          rd_ovf,
  output logic                          out_vld,
  output logic [WORD_W-1:0]             out_word,
  output logic                          out_last
);
  logic                 active, accept, at_end;
  logic [SLOT_BITS-1:0] slot_q;
  logic [HIT_BITS-1:0]  idx_q, last_q;

  assign accept    = rd_req && !active;
  assign at_end    = active && (idx_q == last_q);
  assign rd_ready  = !active;
  assign mem_raddr = {slot_q, idx_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      slot_q   <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      rd_done  <= 1'b0;
      rd_match <= 1'b0;
      rd_count <= '0;
      rd_ovf   <= 1'b0;
      out_vld  <= 1'b0;
      out_word <= '0;
      out_last <= 1'b0;
    end else begin
      rd_done  <= accept;
      out_vld  <= active;
      out_last <= at_end;
      if (active) begin
        out_word <= mem_rdata;
        idx_q    <= idx_q + 1'b1;
        if (at_end) active <= 1'b0;
      end
      if (accept) begin
        rd_match <= lk_match;
        rd_count <= lk_count;
        rd_ovf   <= lk_ovf;
        slot_q   <= rd_tag[SLOT_BITS-1:0];
        idx_q    <= '0;
        last_q   <= HIT_BITS'(lk_count - 1'b1);
        active   <= (lk_count != '0);
      end
    end
  end

  // R5: an unowned slot reports nothing
  assert_mismatch_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && !rd_match |-> (rd_count == '0) && !rd_ovf);
  // R7: last marker only on a valid word
  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_vld);
  // R7: stream has no gaps
  assert_stream_gapless_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_last |=> out_vld);
  // R8: port frees up with the last word
  assert_ready_at_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> rd_ready);
  // R8: a busy port takes no request
  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready |=> !rd_done);
endmodule

// File: rtl/xing_hit_store.sv
module xing_hit_store #(
  parameter int SLOT_BITS = xhs_pkg::XHS_SLOT_BITS,
  parameter int HIT_BITS  = xhs_pkg::XHS_HIT_BITS,
  parameter int TAG_W     = xhs_pkg::XHS_TAG_W,
  parameter int WORD_W    = xhs_pkg::XHS_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_vld,
  input  logic [WORD_W-1:0] hit_word,
  input  logic [TAG_W-1:0]  hit_tag,
  input  logic              rd_req,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_ready,
  output logic              rd_done,
  output logic              rd_match,
  output logic [HIT_BITS:0] rd_count,
  output logic              rd_ovf,
  output logic              out_vld,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last
);
  localparam int ADDR_W = SLOT_BITS + HIT_BITS;

  logic                 wr_store;
  logic [SLOT_BITS-1:0] wr_slot;
  logic [HIT_BITS-1:0]  wr_idx;
  logic                 lk_match, lk_ovf;
  logic [HIT_BITS:0]    lk_count;
  logic [ADDR_W-1:0]    mem_raddr;
  logic [WORD_W-1:0]    mem_rdata;

  xhs_slot_table #(.SLOT_BITS(SLOT_BITS), .HIT_BITS(HIT_BITS), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(hit_vld), .wr_tag(hit_tag),
    .wr_store(wr_store), .wr_slot(wr_slot), .wr_idx(wr_idx),
    .lk_tag(rd_tag), .lk_match(lk_match), .lk_count(lk_count), .lk_ovf(lk_ovf));

  xhs_hit_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .we(wr_store), .waddr({wr_slot, wr_idx}), .wdata(hit_word),
    .raddr(mem_raddr), .rdata(mem_rdata));

  xhs_readout #(.SLOT_BITS(SLOT_BITS), .HIT_BITS(HIT_BITS), .TAG_W(TAG_W), .WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_tag(rd_tag),
    .lk_match(lk_match), .lk_count(lk_count), .lk_ovf(lk_ovf),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .rd_ready(rd_ready), .rd_done(rd_done), .rd_match(rd_match), .rd_count(rd_count),
    .rd_ovf(rd_ovf), .out_vld(out_vld), .out_word(out_word), .out_last(out_last));

  // R1: a stored hit lands in the slot named by the low crossing bits
  assert_slot_ring_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_store |-> (wr_slot == hit_tag[SLOT_BITS-1:0]));
endmodule

// File: tb/tb_xing_hit_store.sv
module tb_xing_hit_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hit_vld = 1'b0;
  logic [17:0] hit_word = '0;
  logic [7:0]  hit_tag = '0;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_tag = '0;
  logic        rd_ready, rd_done, rd_match, rd_ovf, out_vld, out_last;
  logic [3:0]  rd_count;
  logic [17:0] out_word;

  int vectors = 0;
  int fails = 0;

  // reference model
  int          m_tag [64];
  int          m_cnt [64];
  bit          m_ovf [64];
  logic [17:0] m_w   [64][8];

  always #2 clk = ~clk;

  xing_hit_store dut (
    .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_word(hit_word), .hit_tag(hit_tag),
    .rd_req(rd_req), .rd_tag(rd_tag), .rd_ready(rd_ready), .rd_done(rd_done),
    .rd_match(rd_match), .rd_count(rd_count), .rd_ovf(rd_ovf), .out_vld(out_vld),
    .out_word(out_word), .out_last(out_last));

  function automatic int slot_f(input int t);
    return t % 64;
  endfunction

  function automatic int exp_count(input int t);
    return (m_tag[slot_f(t)] == t) ? m_cnt[slot_f(t)] : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_hit(input int t, input logic [17:0] w);
    int s = slot_f(t);
    if (m_tag[s] != t) begin
      m_tag[s] = t; m_cnt[s] = 1; m_ovf[s] = 0; m_w[s][0] = w;
    end else if (m_cnt[s] == 8) begin
      m_ovf[s] = 1;
    end else begin
      m_w[s][m_cnt[s]] = w; m_cnt[s]++;
    end
  endtask

  task automatic send_hit(input int t, input logic [17:0] w);
    @(negedge clk);
    hit_vld = 1'b1; hit_tag = 8'(t); hit_word = w;
    @(posedge clk); #1;
    hit_vld = 1'b0;
    model_hit(t, w);
  endtask

  // same_cycle: a hit for the same crossing accompanies the request
  task automatic read_xing(input int t, input bit same_cycle);
    int s = slot_f(t);
    int ec = exp_count(t);
    bit em = (m_tag[s] == t);
    bit eo = em && m_ovf[s];
    logic [17:0] ew [8];
    logic [17:0] sw = 18'($urandom);
    for (int k = 0; k < 8; k++) ew[k] = m_w[s][k];
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    rd_req = 1'b1; rd_tag = 8'(t);
    if (same_cycle) begin hit_vld = 1'b1; hit_tag = 8'(t); hit_word = sw; end
    @(posedge clk); #1;
    rd_req = 1'b0; hit_vld = 1'b0;
    if (same_cycle) model_hit(t, sw);
    check("R5 done", int'(rd_done), 1);
    check("R5 match", int'(rd_match), int'(em));
    check(same_cycle ? "R6 pre-write count" : "R3 count", int'(rd_count), ec);
    check("R3 ovf", int'(rd_ovf), int'(eo));
    for (int i = 0; i < ec; i++) begin
      @(negedge clk);
      check("R8 ready low", int'(rd_ready), 0);
      if (i == 0) begin rd_req = 1'b1; rd_tag = 8'(t + 1); end
      if ($urandom_range(0, 1) == 1) begin
        hit_vld = 1'b1;
        hit_tag = 8'(t + 1 + $urandom_range(0, 62));
        hit_word = 18'($urandom);
      end
      @(posedge clk); #1;
      rd_req = 1'b0;
      if (hit_vld) model_hit(int'(hit_tag), hit_word);
      hit_vld = 1'b0;
      check("R7 valid", int'(out_vld), 1);
      check("R9 word", int'(out_word), int'(ew[i]));
      check("R7 last", int'(out_last), int'(i == ec - 1));
      check("R8 stray ignored", int'(rd_done), 0);
    end
    if (ec > 0) check("R8 ready after last", int'(rd_ready), 1);
    @(posedge clk); #1;
    check("R7 stream closed", int'(out_vld), 0);
  endtask

  task automatic run_all();
    for (int s = 0; s < 64; s++) begin m_tag[s] = 0; m_cnt[s] = 0; m_ovf[s] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check("R10 ready", int'(rd_ready), 1);
    check("R10 out_vld", int'(out_vld), 0);
    check("R10 done", int'(rd_done), 0);
    @(negedge clk); rst_n = 1'b1;
    read_xing(0, 0);      // R10: crossing 0 owns all slots, count 0
    read_xing(7, 0);      // R5: mismatch after reset
    // R2/R3: fill slot 5 past capacity
    for (int i = 0; i < 10; i++) send_hit(5, 18'(i * 4099 + 17));
    read_xing(5, 0);
    // R1/R5: another crossing sharing slot 5
    read_xing(69, 0);
    // R4: takeover
    send_hit(69, 18'h2aaaa);
    read_xing(69, 0);
    read_xing(5, 0);
    // R6: read and write of same crossing in one cycle
    read_xing(69, 1);
    read_xing(69, 0);
    // R2: exactly eight, no overflow
    for (int i = 0; i < 8; i++) send_hit(200, 18'($urandom));
    read_xing(200, 0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 9);
      int t = $urandom_range(0, 255);
      if (r < 6) send_hit(t, 18'($urandom));
      else if (r < 8) read_xing(t, 1'($urandom_range(0, 1)));
      else read_xing(int'(m_tag[$urandom_range(0, 63)]), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        vectors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule